// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block caches virtual-page-to-physical-frame translations for a processor. Every cached entry also carries the address-space identifier (ASID) of the process that installed it, so translations belonging to several processes can sit side by side. A lookup presents a virtual page number together with the ASID of the running process. All entries are searched in parallel, and a hit answers in one cycle.

On a miss the block fetches the page-table entry from memory on its own. The entry's address is the page-table base input plus the page number scaled by the entry size. A valid entry is installed and then answered. An entry marked invalid is answered as a page fault, and nothing is installed. When every slot is occupied, the least recently used slot is overwritten. Only one miss is handled at a time: while a fetch is in progress, `req_ready` stays low. Two counters tally hits and misses so that software can work out the hit ratio. Two flush inputs invalidate either every entry or only the entries of one ASID.

Top module: `asid_tlb`

## Requirements
- R1: A lookup that matches a valid entry on both page number and ASID gives `resp_valid` high for one cycle, one cycle after acceptance, with that entry's frame in `resp_pfn` and `resp_fault` low. No memory read is issued.
- R2: An entry whose page number matches but whose ASID differs from `req_asid` does not hit, and the lookup is handled as a miss.
- R3: On a miss, `mem_rd_valid` rises with `mem_rd_addr` = `ptbr` + page number × `PTE_BYTES`. It holds that address until `mem_rd_done`. `req_ready` stays low from acceptance until the response.
- R4: The page-table entry word carries the valid flag in bit `PFN_W` and the frame in bits `PFN_W-1:0`. With the flag set, the response follows one cycle after `mem_rd_done` and carries that frame. The pair is installed, so the next identical lookup hits.
- R5: With the valid flag clear, the response has `resp_fault` high and nothing is installed. Repeating the same lookup misses and reads memory again.
- R6: Empty slots are filled before any slot is replaced. When all slots are valid, the slot least recently touched by a hit or an install is replaced.
- R7: Every accepted lookup increments exactly one of `hit_count` or `miss_count`. Faulting lookups count as misses.
- R8: A cycle with `flush_all` high invalidates every entry. In the same cycle it overrides an install.
- R9: A cycle with `flush_asid_en` high invalidates only the entries whose ASID equals `flush_asid`.
- R10: After reset, `req_ready` is high, `resp_valid` and `mem_rd_valid` are low, both counters are zero and no entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr | input | ADDR_W | Page-table base address |
| flush_all | input | 1 | Invalidate every entry |
| flush_asid_en | input | 1 | Invalidate the entries of one ASID |
| flush_asid | input | ASID_W | ASID to invalidate |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Lookup can be accepted |
| req_vpn | input | VPN_W | Virtual page number |
| req_asid | input | ASID_W | ASID of the running process |
| resp_valid | output | 1 | Response strobe |
| resp_fault | output | 1 | Page fault response |
| resp_pfn | output | PFN_W | Translated frame number |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_addr | output | ADDR_W | Table entry address |
| mem_rd_done | input | 1 | Read data valid |
| mem_rd_data | input | PFN_W+1 | Table entry word |
| hit_count | output | CNT_W | Hits counted |
| miss_count | output | CNT_W | Misses counted |

## Verification
The bench builds the block with four entries, 8-bit page and frame numbers, a 4-bit ASID and 8-bit counters. With only four entries, a handful of lookups fills the buffer. The replacement choice between hit-touched and install-touched slots can then be observed directly through hit or miss behaviour at the ports. The narrow page numbers let a bench memory model compute every table entry from its address, and a reserved range of pages returns invalid entries to provoke faults.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES   = 64,
  parameter int VPN_W     = 20,
  parameter int PFN_W     = 20,
  parameter int ASID_W    = 8,
  parameter int ADDR_W    = 32,
  parameter int PTE_BYTES = 4,
  parameter int CNT_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ptbr,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [ASID_W-1:0] req_asid,
  output logic              resp_valid,
  output logic              resp_fault,
  output logic [PFN_W-1:0]  resp_pfn,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_done,
  input  logic [PFN_W:0]    mem_rd_data,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(PTE_BYTES);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  typedef enum logic {S_IDLE, S_FETCH} state_t;
  state_t state;

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [PFN_W-1:0]   e_pfn  [ENTRIES];
  logic [IDX_W-1:0]   age    [ENTRIES];

  logic [VPN_W-1:0]  p_vpn;
  logic [ASID_W-1:0] p_asid;

  logic             hit, found_free, accept, fill_ok, touch_en;
  logic [IDX_W-1:0] hit_idx, victim, touch_idx;

  assign req_ready    = (state == S_IDLE);
  assign mem_rd_valid = (state == S_FETCH);
  assign accept       = req_valid && req_ready;
  assign fill_ok      = mem_rd_valid && mem_rd_done && mem_rd_data[PFN_W];
  assign touch_en     = (accept && hit) || fill_ok;
  assign touch_idx    = (state == S_IDLE) ? hit_idx : victim;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (vld[i] && e_vpn[i] == req_vpn && e_asid[i] == req_asid) begin
        hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
  end

  always_comb begin
    found_free = 1'b0;
    victim = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (!vld[i] && !found_free) begin
        found_free = 1'b1;
        victim = IDX_W'(i);
      end
    if (!found_free)
      for (int i = 0; i < ENTRIES; i++)
        if (age[i] == OLDEST) victim = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      vld         <= '0;
      resp_valid  <= 1'b0;
      resp_fault  <= 1'b0;
      resp_pfn    <= '0;
      mem_rd_addr <= '0;
      p_vpn       <= '0;
      p_asid      <= '0;
      hit_count   <= '0;
      miss_count  <= '0;
      for (int i = 0; i < ENTRIES; i++) age[i] <= IDX_W'(i);
    end else begin
      resp_valid <= 1'b0;
      if (accept) begin
        if (hit) begin
          resp_valid <= 1'b1;
          resp_fault <= 1'b0;
          resp_pfn   <= e_pfn[hit_idx];
          hit_count  <= hit_count + 1'b1;
        end else begin
          p_vpn       <= req_vpn;
          p_asid      <= req_asid;
          mem_rd_addr <= ptbr + ADDR_W'(req_vpn) * STRIDE;
          miss_count  <= miss_count + 1'b1;
          state       <= S_FETCH;
        end
      end
      if (mem_rd_valid && mem_rd_done) begin
        state      <= S_IDLE;
        resp_valid <= 1'b1;
        resp_fault <= !mem_rd_data[PFN_W];
        resp_pfn   <= mem_rd_data[PFN_W] ? mem_rd_data[PFN_W-1:0] : '0;
        if (fill_ok) begin
          vld[victim]    <= 1'b1;
          e_vpn[victim]  <= p_vpn;
          e_asid[victim] <= p_asid;
          e_pfn[victim]  <= mem_rd_data[PFN_W-1:0];
        end
      end
      if (touch_en)
        for (int i = 0; i < ENTRIES; i++)
          if (IDX_W'(i) == touch_idx) age[i] <= '0;
          else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
      for (int i = 0; i < ENTRIES; i++)
        if (flush_all || (flush_asid_en && e_asid[i] == flush_asid)) vld[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/asid_tlb_checker.sv
module asid_tlb_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_fault,
  input logic              mem_rd_valid,
  input logic              mem_rd_done,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);
  a_r3_stall_during_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready);

  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_done) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  a_r4_fill_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && mem_rd_done) |=> (resp_valid && !mem_rd_valid));

  a_r1_resp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(req_valid && req_ready) || $past(mem_rd_valid && mem_rd_done)));

  a_r7_one_counter_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      ((hit_count != $past(hit_count)) != (miss_count != $past(miss_count))));

  a_r5_fault_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault && $rose(resp_valid) |-> $past(mem_rd_valid && mem_rd_done));
endmodule

bind asid_tlb asid_tlb_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_fault(resp_fault), .mem_rd_valid(mem_rd_valid),
  .mem_rd_done(mem_rd_done), .mem_rd_addr(mem_rd_addr),
  .hit_count(hit_count), .miss_count(miss_count));

// File: tb/test_asid_tlb.sv
`timescale 1ns/1ps
module test_asid_tlb;
  localparam int VW = 8, PW = 8, AW = 4, DW = 16, CW = 8;
  localparam logic [DW-1:0] BASE = 16'h1000;

  logic clk = 0, rst_n = 0;
  logic flush_all = 0, flush_asid_en = 0;
  logic [AW-1:0] flush_asid = '0;
  logic req_valid = 0;
  logic [VW-1:0] req_vpn = '0;
  logic [AW-1:0] req_asid = '0;
  logic req_ready, resp_valid, resp_fault, mem_rd_valid;
  logic [PW-1:0] resp_pfn;
  logic [DW-1:0] mem_rd_addr;
  logic mem_rd_done = 0;
  logic [PW:0] mem_rd_data = '0;
  logic [CW-1:0] hit_count, miss_count;

  int checks = 0, fails = 0, reads = 0, wait_cnt = 0, stall_bad = 0;
  logic [DW-1:0] last_addr = '0;

  always #4 clk = ~clk;

  asid_tlb #(.ENTRIES(4), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW), .ADDR_W(DW),
             .PTE_BYTES(4), .CNT_W(CW)) i_asid_tlb (
    .clk(clk), .rst_n(rst_n), .ptbr(BASE), .flush_all(flush_all),
    .flush_asid_en(flush_asid_en), .flush_asid(flush_asid),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn), .req_asid(req_asid),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_pfn(resp_pfn),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_done(mem_rd_done),
    .mem_rd_data(mem_rd_data), .hit_count(hit_count), .miss_count(miss_count));

  // memory model: pages 0xF0 and above hold invalid entries, others map to vpn ^ 0x5A
  always @(negedge clk) begin
    if (mem_rd_done) mem_rd_done <= 0;
    else if (mem_rd_valid) begin
      if (req_ready) stall_bad <= stall_bad + 1;
      wait_cnt <= wait_cnt + 1;
      if (wait_cnt == 1) begin
        logic [VW-1:0] v;
        v = VW'((mem_rd_addr - BASE) >> 2);
        mem_rd_data <= (v >= 8'hF0) ? {1'b0, v} : {1'b1, v ^ 8'h5A};
        mem_rd_done <= 1;
        last_addr <= mem_rd_addr;
        reads <= reads + 1;
        wait_cnt <= 0;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  int l_cyc, l_reads;
  logic l_fault;
  logic [PW-1:0] l_pfn;

  task automatic lookup(input logic [VW-1:0] v, input logic [AW-1:0] a);
    int r0;
    @(negedge clk);
    r0 = reads;
    req_valid = 1; req_vpn = v; req_asid = a;
    @(negedge clk);
    req_valid = 0;
    l_cyc = 1;
    while (!resp_valid && l_cyc < 30) begin @(negedge clk); l_cyc++; end
    l_fault = resp_fault; l_pfn = resp_pfn; l_reads = reads - r0;
  endtask

  task automatic expect_hit(input string req, input logic [VW-1:0] v, input logic [AW-1:0] a);
    lookup(v, a);
    check({req, " hit latency"}, l_cyc, 1);
    check({req, " hit no read"}, l_reads, 0);
    check({req, " hit frame"}, l_pfn, v ^ 8'h5A);
  endtask

  task automatic expect_miss(input string req, input logic [VW-1:0] v, input logic [AW-1:0] a);
    lookup(v, a);
    check({req, " miss read"}, l_reads, 1);
    check({req, " miss frame"}, l_pfn, v ^ 8'h5A);
  endtask

  task automatic pulse_flush(input logic all, input logic [AW-1:0] a);
    @(negedge clk);
    flush_all = all; flush_asid_en = !all; flush_asid = a;
    @(negedge clk);
    flush_all = 0; flush_asid_en = 0;
  endtask

  task automatic t_reset();
    check("R10 ready", req_ready, 1);
    check("R10 resp_valid", resp_valid, 0);
    check("R10 mem_rd_valid", mem_rd_valid, 0);
    check("R10 hit_count", hit_count, 0);
    check("R10 miss_count", miss_count, 0);
  endtask

  task automatic t_fill();
    expect_miss("R3", 8'h12, 4'd1);
    check("R3 address", last_addr, BASE + 16'h48);
    check("R3 stall while fetching", stall_bad, 0);
    check("R4 no fault", l_fault, 0);
    expect_hit("R4 installed / R1", 8'h12, 4'd1);
  endtask

  task automatic t_asid();
    expect_miss("R2 other ASID", 8'h12, 4'd2);
    expect_hit("R2 original ASID kept", 8'h12, 4'd1);
  endtask

  task automatic t_fault();
    lookup(8'hF3, 4'd1);
    check("R5 fault flag", l_fault, 1);
    check("R5 read issued", l_reads, 1);
    lookup(8'hF3, 4'd1);
    check("R5 not installed", l_reads, 1);
    check("R5 fault again", l_fault, 1);
    check("R7 hits", hit_count, 2);
    check("R7 misses", miss_count, 4);
  endtask

  task automatic t_flush();
    pulse_flush(0, 4'd1);
    expect_hit("R9 other ASID kept", 8'h12, 4'd2);
    expect_miss("R9 flushed ASID", 8'h12, 4'd1);
    pulse_flush(1, 4'd0);
    expect_miss("R8 all flushed a2", 8'h12, 4'd2);
    expect_miss("R8 all flushed a1", 8'h12, 4'd1);
  endtask

  task automatic t_lru();
    int h0, m0;
    pulse_flush(1, 4'd0);
    h0 = hit_count; m0 = miss_count;
    for (int k = 1; k <= 4; k++) expect_miss("R6 fill empty", VW'(k), 4'd3);
    for (int k = 1; k <= 4; k++) expect_hit("R6 all four held", VW'(k), 4'd3);
    expect_hit("R6 touch 1", 8'h01, 4'd3);
    expect_miss("R6 evict", 8'h05, 4'd3);
    expect_miss("R6 LRU 2 evicted", 8'h02, 4'd3);
    expect_hit("R6 recent 1 kept", 8'h01, 4'd3);
    expect_hit("R6 new 5 kept", 8'h05, 4'd3);
    check("R7 hit delta", int'(hit_count) - h0, 7);
    check("R7 miss delta", int'(miss_count) - m0, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_asid();
    t_fault();
    t_flush();
    t_lru();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule